// File: doc/BRIEF.md
# Tile Hysteresis Threshold Generator

This block turns the gradient magnitudes of one image tile into a pair of hysteresis thresholds for that tile alone. A magnitude stream arrives with a start-of-tile flag on its first sample and an end-of-tile flag on its last sample. The tile's class code, produced by an external classifier, comes in alongside the first sample. Every accepted magnitude adds to one of 64 equal-width bins, selected by the magnitude's top six bits. When the last sample arrives, a sequencer walks the bins from the lowest upward and keeps a running total. It stops at the first bin whose running total reaches a class-dependent fraction of the tile's sample count.

The upper edge of that bin is the high threshold. The low threshold is a fixed fraction, about 0.4, of the high threshold, formed with shifts and adds. Both values appear with a one-cycle valid pulse. While the walk is in progress the block reports itself busy and discards every incoming sample. A downstream edge-linking stage consumes the threshold pair.

Top module: `tile_thresh_gen`

## Requirements
- R1: After reset, `busy` and `out_valid` are low and `out_hi` and `out_lo` are zero.
- R2: An accepted magnitude adds one to bin `in_mag >> (MAG_W-6)`. The 64 bins therefore have equal width `2^(MAG_W-6)`.
- R3: A sample flagged `in_sob` starts a new tile. It clears every bin and the sample count, and it is then counted as the first sample, so each result depends only on its own tile's samples.
- R4: The class code, captured with the start sample, selects the target fraction q/256. With the defaults, class 0 uses q=230, class 1 uses q=200, class 2 uses q=179 and class 3 uses q=128.
- R5: Let N be the tile's sample count and C(k) the total count of bins 0..k. For the smallest k with 256*C(k) >= q*N, `out_hi` = k*2^(MAG_W-6) + 2^(MAG_W-6) - 1.
- R6: `out_lo` = floor(`out_hi`*102/256).
- R7: `busy` is high from the cycle after the end sample for exactly k+1 cycles, and never for more than 64 cycles. `out_valid` pulses for one cycle as `busy` falls.
- R8: Samples presented while `busy` is high are ignored, including those flagged as the start of a tile.
- R9: `out_hi` and `out_lo` keep their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sob | input | 1 | Sample is the first of a tile |
| in_eob | input | 1 | Sample is the last of a tile |
| in_mag | input | MAG_W | Unsigned gradient magnitude |
| in_type | input | TYPE_W | Tile class code, taken with the first sample |
| busy | output | 1 | Bin walk in progress; samples are dropped |
| out_valid | output | 1 | One-cycle strobe for a new threshold pair |
| out_hi | output | MAG_W | High hysteresis threshold |
| out_lo | output | MAG_W | Low hysteresis threshold |

## Verification
A bin counter that is not cleared, or one that picks up a stray sample, moves the running total. This shows up as a wrong `out_hi` and a wrong `out_lo` on the next valid pulse of the affected tile. It also changes the length of the busy window, which the bench measures in cycles. A walk index that sticks or skips a bin alters that busy length and the threshold at the same time, and it surfaces at the end of the tile's walk, at most 64 cycles after the last sample. A sample that leaks in during the walk changes the count mid-search, and the threshold of the tile being searched deviates from the arithmetic model.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int HIST_BITS = 6;
  localparam int HIST_BINS = 1 << HIST_BITS;
  localparam int FRAC_W    = 8;

  // bin index from the top bits of a magnitude
  function automatic logic [HIST_BITS-1:0] bin_of(input logic [31:0] mag, input int mag_w);
    logic [31:0] sh;
    sh = mag >> (mag_w - HIST_BITS);
    return sh[HIST_BITS-1:0];
  endfunction

  // upper edge of bin k
  function automatic logic [31:0] hi_of_bin(input logic [HIST_BITS-1:0] k, input int mag_w);
    int s;
    s = mag_w - HIST_BITS;
    return (32'(k) << s) | ((32'd1 << s) - 32'd1);
  endfunction

  // floor(hi * 102 / 256), 102 = 64 + 32 + 4 + 2
  function automatic logic [31:0] lo_of_hi(input logic [31:0] hi);
    logic [39:0] w;
    logic [39:0] acc;
    w   = {8'b0, hi};
    acc = (w << 6) + (w << 5) + (w << 2) + (w << 1);
    return acc[39:8];
  endfunction

  // 256 * cum >= q * total
  function automatic logic reached(input logic [31:0] cum, input logic [31:0] total,
                                   input logic [FRAC_W-1:0] q);
    logic [63:0] lhs;
    logic [63:0] rhs;
    lhs = {24'b0, cum, 8'b0};
    rhs = 64'(total) * 64'(q);
    return lhs >= rhs;
  endfunction
endpackage

// File: rtl/tg_hist.sv
module tg_hist #(
  parameter int CNT_W = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          inc,
  input  logic [tg_pkg::HIST_BITS-1:0]  bin,
  input  logic [tg_pkg::HIST_BITS-1:0]  rd_idx,
  output logic [CNT_W-1:0]              rd_cnt
);
  localparam int NB = tg_pkg::HIST_BINS;

  logic [NB*CNT_W-1:0] cnt_flat;

  for (genvar g = 0; g < NB; g++) begin : g_bin
    logic             hit;
    logic [CNT_W-1:0] cnt;
    assign hit = inc && (bin == tg_pkg::HIST_BITS'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= hit ? CNT_W'(1) : '0;
      else if (hit)  cnt <= cnt + CNT_W'(1);
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt;
  end

  assign rd_cnt = cnt_flat[32'(rd_idx)*CNT_W +: CNT_W];
endmodule

// File: rtl/tg_intake.sv
module tg_intake #(
  parameter int CNT_W  = 11,
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sob,
  input  logic              in_eob,
  input  logic [TYPE_W-1:0] in_type,
  input  logic              busy,
  output logic              smp_acc,
  output logic              sob_acc,
  output logic              eob_acc,
  output logic [CNT_W-1:0]  pix_cnt,
  output logic [TYPE_W-1:0] type_q
);
  logic in_blk;

  assign smp_acc = in_valid && !busy && (in_sob || in_blk);
  assign sob_acc = smp_acc && in_sob;
  assign eob_acc = smp_acc && in_eob;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_blk  <= 1'b0;
      pix_cnt <= '0;
      type_q  <= '0;
    end else begin
      if (eob_acc)      in_blk <= 1'b0;
      else if (sob_acc) in_blk <= 1'b1;
      if (sob_acc) begin
        pix_cnt <= CNT_W'(1);
        type_q  <= in_type;
      end else if (smp_acc) begin
        pix_cnt <= pix_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tg_scan.sv
module tg_scan #(
  parameter int MAG_W = 10,
  parameter int CNT_W = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [CNT_W-1:0]              total,
  input  logic [tg_pkg::FRAC_W-1:0]     q,
  input  logic [CNT_W-1:0]              rd_cnt,
  output logic [tg_pkg::HIST_BITS-1:0]  rd_idx,
  output logic                          busy,
  output logic                          out_valid,
  output logic [MAG_W-1:0]              out_hi,
  output logic [MAG_W-1:0]              out_lo
);
  localparam logic [tg_pkg::HIST_BITS-1:0] LAST = '1;

  logic [CNT_W-1:0] cum_q;
  logic [CNT_W-1:0] cum_nx;
  logic             hit;
  logic             stop;
  logic [31:0]      hi_w;

  always_comb begin
    cum_nx = cum_q + rd_cnt;
    hit    = tg_pkg::reached(32'(cum_nx), 32'(total), q);
    stop   = hit || (rd_idx == LAST);
    hi_w   = tg_pkg::hi_of_bin(rd_idx, MAG_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rd_idx    <= '0;
      cum_q     <= '0;
      out_valid <= 1'b0;
      out_hi    <= '0;
      out_lo    <= '0;
    end else begin
      out_valid <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        rd_idx <= '0;
        cum_q  <= '0;
      end else if (busy) begin
        if (stop) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_hi    <= MAG_W'(hi_w);
          out_lo    <= MAG_W'(tg_pkg::lo_of_hi(hi_w));
        end else begin
          rd_idx <= rd_idx + 1'b1;
          cum_q  <= cum_nx;
        end
      end
    end
  end
endmodule

// File: rtl/tile_thresh_gen.sv
module tile_thresh_gen #(
  parameter int MAG_W   = 10,
  parameter int MAX_PIX = 1024,
  parameter int TYPE_W  = 2,
  parameter logic [(1<<TYPE_W)*8-1:0] PCT_TABLE = {8'd128, 8'd179, 8'd200, 8'd230}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sob,
  input  logic              in_eob,
  input  logic [MAG_W-1:0]  in_mag,
  input  logic [TYPE_W-1:0] in_type,
  output logic              busy,
  output logic              out_valid,
  output logic [MAG_W-1:0]  out_hi,
  output logic [MAG_W-1:0]  out_lo
);
  localparam int CNT_W = $clog2(MAX_PIX + 1);
  localparam int FW    = tg_pkg::FRAC_W;

  // named internal events
  logic                         smp_acc;
  logic                         sob_acc;
  logic                         eob_acc;
  logic [CNT_W-1:0]             pix_cnt;
  logic [TYPE_W-1:0]            type_q;
  logic [FW-1:0]                q_sel;
  logic [tg_pkg::HIST_BITS-1:0] bin_idx;
  logic [tg_pkg::HIST_BITS-1:0] rd_idx;
  logic [CNT_W-1:0]             rd_cnt;

  assign bin_idx = tg_pkg::bin_of(32'(in_mag), MAG_W);
  assign q_sel   = PCT_TABLE[32'(type_q)*FW +: FW];

  tg_intake #(.CNT_W(CNT_W), .TYPE_W(TYPE_W)) u_intake (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob), .in_eob(in_eob),
    .in_type(in_type), .busy(busy), .smp_acc(smp_acc), .sob_acc(sob_acc),
    .eob_acc(eob_acc), .pix_cnt(pix_cnt), .type_q(type_q)
  );

  tg_hist #(.CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(sob_acc), .inc(smp_acc), .bin(bin_idx),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt)
  );

  tg_scan #(.MAG_W(MAG_W), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(eob_acc), .total(pix_cnt), .q(q_sel),
    .rd_cnt(rd_cnt), .rd_idx(rd_idx), .busy(busy), .out_valid(out_valid),
    .out_hi(out_hi), .out_lo(out_lo)
  );
endmodule

// File: rtl/tile_thresh_gen_chk.sv
module tile_thresh_gen_chk #(
  parameter int MAG_W = 10,
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             out_valid,
  input logic [MAG_W-1:0] out_hi,
  input logic [MAG_W-1:0] out_lo,
  input logic             sob_acc,
  input logic [CNT_W-1:0] pix_cnt
);
  logic [7:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 8'd1;
    else           busy_run <= '0;
  end

  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !busy); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R7
  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_run <= 8'd64); // R7
  AST_HI_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (&out_hi[MAG_W-7:0])); // R5
  AST_LO_BELOW_HI: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_lo < out_hi); // R6
  AST_SOB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) sob_acc |=> pix_cnt == CNT_W'(1)); // R3
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(pix_cnt)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_hi) && $stable(out_lo)); // R9
endmodule

bind tile_thresh_gen tile_thresh_gen_chk #(.MAG_W(MAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid), .out_hi(out_hi),
  .out_lo(out_lo), .sob_acc(sob_acc), .pix_cnt(pix_cnt)
);

// File: tb/tile_thresh_gen_tb.sv
module tile_thresh_gen_tb;
  localparam int MAG_W = 10;
  localparam int BW    = 16;   // bin width 2^(10-6)
  localparam int MAXN  = 256;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_sob = 1'b0;
  logic             in_eob = 1'b0;
  logic [MAG_W-1:0] in_mag = '0;
  logic [1:0]       in_type = '0;
  logic             busy;
  logic             out_valid;
  logic [MAG_W-1:0] out_hi;
  logic [MAG_W-1:0] out_lo;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int mags [MAXN];

  always #5 clk = ~clk;

  tile_thresh_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob), .in_eob(in_eob),
    .in_mag(in_mag), .in_type(in_type), .busy(busy), .out_valid(out_valid),
    .out_hi(out_hi), .out_lo(out_lo)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired: actual=%0d cycles expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int q_of(input int t);
    case (t)
      0: return 230;
      1: return 200;
      2: return 179;
      default: return 128;
    endcase
  endfunction

  // run one tile of n samples in mags[], class t
  task automatic run_tile(input int t, input int n);
    int hist [64];
    int cum;
    int kx;
    int hi_e;
    int lo_e;
    int bcyc;
    int guard;
    for (int b = 0; b < 64; b++) hist[b] = 0;
    for (int i = 0; i < n; i++) hist[mags[i] / BW] += 1;   // R2 equal-width bins
    cum = 0;
    kx = 63;
    for (int b = 0; b < 64; b++) begin
      cum += hist[b];
      if (cum * 256 >= q_of(t) * n) begin kx = b; break; end
    end
    hi_e = kx * BW + BW - 1;
    lo_e = (hi_e * 102) / 256;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sob   = (i == 0);
      in_eob   = (i == n - 1);
      in_mag   = MAG_W'(mags[i]);
      in_type  = 2'(t);
    end
    @(negedge clk);
    // junk during the walk: a tile start with the largest magnitude (R8)
    in_valid = 1'b1; in_sob = 1'b1; in_eob = 1'b1; in_mag = '1; in_type = 2'd3;
    bcyc = 0;
    guard = 0;
    while (!out_valid && guard < 200) begin
      if (busy) bcyc++;
      @(negedge clk);
      guard++;
    end
    in_valid = 1'b0; in_sob = 1'b0; in_eob = 1'b0;
    check("R7", "valid strobe seen", int'(out_valid), 1);
    check("R5 R4 R8", "high threshold", int'(out_hi), hi_e);
    check("R6", "low threshold", int'(out_lo), lo_e);
    check("R7", "busy cycles", bcyc, kx + 1);
    @(negedge clk);
    check("R7", "strobe is one cycle", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    check("R9", "high held", int'(out_hi), hi_e);
    check("R9", "low held", int'(out_lo), lo_e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "valid after reset", int'(out_valid), 0);
    check("R1", "hi after reset", int'(out_hi), 0);
    check("R1", "lo after reset", int'(out_lo), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 4; t++) begin
      // uniform value
      for (int i = 0; i < 64; i++) mags[i] = 300 + 37 * t;
      run_tile(t, 64);
      // ramp, one sample per bin
      for (int i = 0; i < 64; i++) mags[i] = i * 16 + t;
      run_tile(t, 64);
      // single spike on a flat floor
      for (int i = 0; i < 64; i++) mags[i] = 5;
      mags[17] = 1023;
      run_tile(t, 64);
      // mixed spread, longer tile (R3: earlier tiles must not leak in)
      for (int i = 0; i < 200; i++) mags[i] = (i * i * 7 + 13 + t * 101) % 1024;
      run_tile(t, 200);
    end
    // one-sample tile in the top bin: longest walk (R7)
    mags[0] = 1023;
    run_tile(0, 1);
    // every bin-edge value on a slow ramp (R2)
    for (int i = 0; i < 256; i++) mags[i] = (i * 4) | 3;
    run_tile(3, 256);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule